// File: doc/BRIEF.md
# Video DAC Pedestal Decoder

This block drives the digital side of a current-steering video DAC. On each falling clock edge it captures an 8-bit straight-binary pixel code together with five active-low controls: blanking, sync, reference white, overbright and straight-DAC mode. It turns them into a single 9-bit drive level, counted in DAC LSB units, and registers that level one clock later.

In video mode the level includes a black pedestal of 21 LSB and a blank pedestal of 111 LSB, and it can add an overbright pedestal of 27 LSB. The controls can force the pixel code to zero or to full scale, or remove pedestals, following a fixed priority. In straight-DAC mode all pedestals are switched off and only the forcing of the code remains. A second registered output gives the complementary level, which is the mode's full scale minus the main level. It feeds the inverted current output.

Top module: `vdac_pedestal_pipe`

## Requirements
- R1: Inputs are captured on the falling clock edge. The level decoded from them appears on the outputs at the next falling edge, one full clock later. Until then the outputs keep their previous value.
- R2: While rst_n is low at a falling edge, both stages load their idle state: every control inactive (1) and pixel 0. The outputs then read level 132 and complement 282.
- R3: In video mode (straight_n_i=1) with every other control at 1, the level is pixel + 132. The level never exceeds 414.
- R4: blank_n_i=0 forces the code to 0 and drops the 21 LSB black pedestal. It overrides white_n_i and over_n_i, so with sync_n_i=1 in video mode the level is 111.
- R5: sync_n_i=0 drops the 111 LSB blank pedestal and overrides nothing else. Sync alone gives pixel + 21, and sync with blank gives 0.
- R6: white_n_i=0 forces the code to 255, which gives 387 in video mode. Together with over_n_i=0 the level is 414.
- R7: over_n_i=0 adds 27 LSB in video mode without changing the code. Pixel p then gives p + 159.
- R8: straight_n_i=0 disables all three pedestals, so the level equals the code. In this mode blank_n_i=0 still forces 0 and white_n_i=0 still forces 255, with blank taking priority.
- R9: level_cmp_o equals the full scale minus level_o. Full scale is 414 in video mode and 255 in straight-DAC mode.
- R10: level_o and level_cmp_o are both registered and change on the same falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers act on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_i | input | 8 | Pixel code, straight binary, bit 0 is the LSB |
| blank_n_i | input | 1 | Blanking, active low |
| sync_n_i | input | 1 | Sync, active low |
| white_n_i | input | 1 | Reference-white force, active low |
| over_n_i | input | 1 | Overbright pedestal, active low |
| straight_n_i | input | 1 | Straight-DAC mode, active low |
| level_o | output | 9 | Registered drive level in LSB units |
| level_cmp_o | output | 9 | Registered complementary level |

## Verification
Blanking and reference white both try to set the code in the same captured cycle. The bench provokes this by pulling both low together, with overbright also low, in video mode and again in straight-DAC mode. It judges the result as 111 and 0, which shows that blanking won and that the overbright pedestal stayed out. Sync and blank are also asserted together to confirm that both pedestal removals combine to 0. Every expected level is a fixed number taken from the requirements and is sampled after the second falling edge.

// File: rtl/vdac_pkg.sv
// vdac_pkg: shared control bundle for the pedestal decoder.
// Assumes every control is active low (0 = asserted, 1 = idle).
package vdac_pkg;
    typedef struct packed {
        logic straight_n;
        logic over_n;
        logic white_n;
        logic sync_n;
        logic blank_n;
    } vctl_t;

    localparam vctl_t VCTL_IDLE = '{straight_n: 1'b1, over_n: 1'b1, white_n: 1'b1,
                                    sync_n: 1'b1, blank_n: 1'b1};
endpackage

// File: rtl/vdac_capture.sv
// vdac_capture: first pipeline stage. Samples the pixel code and the control
// bundle on the falling clock edge.
// Assumes rst_n is synchronous to the same falling edge.
module vdac_capture
    import vdac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_i,
    input  vctl_t             ctl_i,
    output logic [DATA_W-1:0] pix_q,
    output vctl_t             ctl_q
);
    // Input capture register; reset loads the idle bundle and zero data.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
            ctl_q <= VCTL_IDLE;
        end else begin
            pix_q <= pix_i;
            ctl_q <= ctl_i;
        end
    end
endmodule

// File: rtl/vdac_decode.sv
// vdac_decode: combinational map from the captured code and controls to a
// drive level and its complement.
// Assumes the controls are active low. Blank has priority over white when
// the code is forced, and the pedestals are gated by the straight-DAC mode.
module vdac_decode
    import vdac_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LVL_W     = 9,
    parameter int BLACK_PED = 21,
    parameter int BLANK_PED = 111,
    parameter int OVER_PED  = 27
) (
    input  logic [DATA_W-1:0] pix_i,
    input  vctl_t             ctl_i,
    output logic [LVL_W-1:0]  lvl_o,
    output logic [LVL_W-1:0]  cmp_o
);
    localparam int DATA_MAX   = (1 << DATA_W) - 1;
    localparam int VIDEO_FULL = DATA_MAX + BLACK_PED + BLANK_PED + OVER_PED;

    logic [DATA_W-1:0] code;
    logic              video;
    logic [LVL_W-1:0]  ped_black, ped_blank, ped_over, full;

    // Code forcing: blank wins over white, otherwise the pixel passes.
    always_comb begin
        if (!ctl_i.blank_n)      code = '0;
        else if (!ctl_i.white_n) code = {DATA_W{1'b1}};
        else                     code = pix_i;
    end

    // Pedestal selection; each one is gated by video mode.
    always_comb begin
        video     = ctl_i.straight_n;
        ped_black = (video && ctl_i.blank_n) ? LVL_W'(BLACK_PED) : '0;
        ped_blank = (video && ctl_i.sync_n)  ? LVL_W'(BLANK_PED) : '0;
        ped_over  = (video && ctl_i.blank_n && !ctl_i.over_n) ? LVL_W'(OVER_PED) : '0;
        full      = video ? LVL_W'(VIDEO_FULL) : LVL_W'(DATA_MAX);
    end

    // Sum of code and pedestals, and the complement against the mode's full scale.
    always_comb begin
        lvl_o = LVL_W'(code) + ped_black + ped_blank + ped_over;
        cmp_o = full - lvl_o;
    end
endmodule

// File: rtl/vdac_outreg.sv
// vdac_outreg: second pipeline stage. Holds the level and its complement so
// that both change on one falling edge.
// Assumes reset values match the decode of the idle capture state.
module vdac_outreg #(
    parameter int LVL_W   = 9,
    parameter int RST_LVL = 132,
    parameter int RST_CMP = 282
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0] cmp_i,
    output logic [LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0] cmp_q
);
    // Output register pair, loaded together.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_W'(RST_LVL);
            cmp_q <= LVL_W'(RST_CMP);
        end else begin
            lvl_q <= lvl_i;
            cmp_q <= cmp_i;
        end
    end
endmodule

// File: rtl/vdac_pedestal_pipe.sv
// vdac_pedestal_pipe: two-stage falling-edge pipeline that captures the
// pixel code and active-low controls, then emits a pedestal-adjusted level
// and its complement one clock later.
// Assumes the controls are held idle (1) when unused.
module vdac_pedestal_pipe
    import vdac_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BLACK_PED = 21,
    parameter int BLANK_PED = 111,
    parameter int OVER_PED  = 27,
    parameter int LVL_W     = $clog2((1 << DATA_W) - 1 + BLACK_PED + BLANK_PED + OVER_PED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              blank_n_i,
    input  logic              sync_n_i,
    input  logic              white_n_i,
    input  logic              over_n_i,
    input  logic              straight_n_i,
    output logic [LVL_W-1:0]  level_o,
    output logic [LVL_W-1:0]  level_cmp_o
);
    localparam int DATA_MAX   = (1 << DATA_W) - 1;
    localparam int VIDEO_FULL = DATA_MAX + BLACK_PED + BLANK_PED + OVER_PED;
    localparam int IDLE_LVL   = BLACK_PED + BLANK_PED;

    vctl_t             ctl_in, cap_ctl;
    logic [DATA_W-1:0] cap_pix;
    logic [LVL_W-1:0]  dec_lvl, dec_cmp;

    // Bundle the loose control pins.
    always_comb begin
        ctl_in = '{straight_n: straight_n_i, over_n: over_n_i, white_n: white_n_i,
                   sync_n: sync_n_i, blank_n: blank_n_i};
    end

    vdac_capture #(.DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .ctl_i(ctl_in),
        .pix_q(cap_pix), .ctl_q(cap_ctl)
    );

    vdac_decode #(
        .DATA_W(DATA_W), .LVL_W(LVL_W), .BLACK_PED(BLACK_PED),
        .BLANK_PED(BLANK_PED), .OVER_PED(OVER_PED)
    ) dec_i (
        .pix_i(cap_pix), .ctl_i(cap_ctl), .lvl_o(dec_lvl), .cmp_o(dec_cmp)
    );

    vdac_outreg #(
        .LVL_W(LVL_W), .RST_LVL(IDLE_LVL), .RST_CMP(VIDEO_FULL - IDLE_LVL)
    ) out_i (
        .clk(clk), .rst_n(rst_n), .lvl_i(dec_lvl), .cmp_i(dec_cmp),
        .lvl_q(level_o), .cmp_q(level_cmp_o)
    );

    AST_LEVEL_MAX: assert property (@(negedge clk) disable iff (!rst_n)
        int'(level_o) <= VIDEO_FULL); // R3
    AST_CMP_SUM: assert property (@(negedge clk) disable iff (!rst_n)
        (int'(level_o) + int'(level_cmp_o) == VIDEO_FULL) ||
        (int'(level_o) + int'(level_cmp_o) == DATA_MAX)); // R9
    AST_BLANK_SYNC_ZERO: assert property (@(negedge clk) disable iff (!rst_n)
        (!cap_ctl.blank_n && !cap_ctl.sync_n) |=> (level_o == '0)); // R5
    AST_WHITE_OVER_TOP: assert property (@(negedge clk) disable iff (!rst_n)
        (cap_ctl.straight_n && cap_ctl.blank_n && cap_ctl.sync_n &&
         !cap_ctl.white_n && !cap_ctl.over_n) |=> (int'(level_o) == VIDEO_FULL)); // R6
    AST_STRAIGHT_PASS: assert property (@(negedge clk) disable iff (!rst_n)
        (!cap_ctl.straight_n && cap_ctl.blank_n && cap_ctl.white_n)
        |=> (level_o == LVL_W'($past(cap_pix)))); // R8
endmodule

// File: tb/vdac_pedestal_pipe_tb.sv
`timescale 1ns/1ps
module vdac_pedestal_pipe_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix = 8'd0;
    logic       b_n = 1'b1, s_n = 1'b1, w_n = 1'b1, o_n = 1'b1, st_n = 1'b1;
    logic [8:0] lvl, cmp;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    vdac_pedestal_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .pix_i(pix), .blank_n_i(b_n), .sync_n_i(s_n),
        .white_n_i(w_n), .over_n_i(o_n), .straight_n_i(st_n),
        .level_o(lvl), .level_cmp_o(cmp)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at the rising edge, then sample after the second falling edge.
    task automatic apply(input logic [7:0] p, input logic b, input logic s,
                         input logic w, input logic o, input logic st,
                         input int e_lvl, input int e_cmp, input string req);
        @(posedge clk);
        pix = p; b_n = b; s_n = s; w_n = w; o_n = o; st_n = st;
        @(negedge clk);
        @(negedge clk);
        #2;
        check(req, int'(lvl), e_lvl);
        check(req, int'(cmp), e_cmp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check("R2", int'(lvl), 132);
        check("R2", int'(cmp), 282);
        @(posedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_video;
        apply(8'd0,   1,1,1,1,1, 132, 282, "R3");
        apply(8'd100, 1,1,1,1,1, 232, 182, "R3");
        apply(8'd255, 1,1,1,1,1, 387, 27,  "R3");
    endtask

    task automatic t_latency;
        apply(8'd50, 1,1,1,1,1, 182, 232, "R1");
        @(posedge clk);
        pix = 8'd200;
        @(negedge clk);
        #2;
        check("R1", int'(lvl), 182);
        check("R10", int'(cmp), 232);
        @(negedge clk);
        #2;
        check("R1", int'(lvl), 332);
        check("R10", int'(cmp), 82);
    endtask

    task automatic t_blank;
        apply(8'd77, 0,1,1,1,1, 111, 303, "R4");
        apply(8'd77, 0,1,0,0,1, 111, 303, "R4");
    endtask

    task automatic t_sync;
        apply(8'd40, 1,0,1,1,1, 61, 353, "R5");
        apply(8'd40, 0,0,1,1,1, 0,  414, "R5");
    endtask

    task automatic t_white;
        apply(8'd12, 1,1,0,1,1, 387, 27, "R6");
        apply(8'd12, 1,1,0,0,1, 414, 0,  "R6");
    endtask

    task automatic t_over;
        apply(8'd100, 1,1,1,0,1, 259, 155, "R7");
        apply(8'd0,   1,1,1,0,1, 159, 255, "R7");
    endtask

    task automatic t_straight;
        apply(8'd200, 1,1,1,1,0, 200, 55,  "R8");
        apply(8'd200, 1,0,1,0,0, 200, 55,  "R8");
        apply(8'd200, 0,1,1,1,0, 0,   255, "R8");
        apply(8'd9,   1,1,0,1,0, 255, 0,   "R8");
        apply(8'd9,   0,1,0,0,0, 0,   255, "R9");
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_video();
        t_latency();
        t_blank();
        t_sync();
        t_white();
        t_over();
        t_straight();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule